// File: doc/BRIEF.md
# EEPROM Page-Write Engine

This block is a clocked behavioural model of the write and status logic of a byte-wide parallel EEPROM. It samples three active-low strobes (chip select, output enable, write enable), an address bus and an 8-bit data bus on every rising clock edge. Accepted byte writes go into a page buffer. When the host stops issuing write strobes for a programmable number of cycles, the engine runs a self-timed programming cycle. That cycle sweeps the buffered bytes into a small internal array.

While programming is in progress, a read does not return array contents. It returns a status byte: bit 7 holds the inverse of bit 7 of the most recently accepted byte, and bit 6 flips on every new read access. Host software can poll either bit to learn when programming has finished. All time spans are counted in clock cycles and scaled down for simulation. The array holds `PAGES` pages of `PAGE_BYTES` bytes. The page number is the address bits above the byte offset.

Top module: `eeprom_page_engine`

## Requirements
- R1: A byte write is accepted only while `cs_n` and `we_n` are both low and `oe_n` is high. A strobe made with `oe_n` low, or with `cs_n` high, stores nothing and does not start programming.
- R2: The address is taken in the first cycle in which the write condition of R1 holds. The data is taken from the last cycle in which that condition holds.
- R3: A write condition that lasts fewer than `MIN_LOW_CYC` consecutive clock cycles is discarded.
- R4: The first accepted byte fixes the page (the address bits above the low log2(`PAGE_BYTES`) offset bits). Later bytes addressed to another page are discarded.
- R5: Once a page is open, programming starts no earlier than `TIMEOUT_CYC`+1 and no later than `TIMEOUT_CYC`+4 cycles after the write strobe of the last accepted byte ends. Any new write strobe inside that window keeps the page loading.
- R6: `busy` stays high for exactly max(`PROG_CYC`, `PAGE_BYTES`) cycles per programming cycle.
- R7: While `busy` is high, a read returns bit 7 equal to the inverse of bit 7 of the last accepted byte, with bits 5:0 equal to zero.
- R8: While `busy` is high, bit 6 of the read value inverts on every new read access, where a read access starts when `cs_n` and `oe_n` become both low.
- R9: Write strobes made while `busy` is high are ignored. They change neither the array nor the status bit 7.
- R10: When `busy` is low, a read returns the array byte one clock after the read strobe is sampled. `rdata` is zero in any cycle that follows a cycle without a read. Bytes that no programming cycle touched keep their value.
- R11: After reset, `busy` and `rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | log2(PAGES*PAGE_BYTES) | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data or status byte |
| busy | output | 1 | High while the programming cycle runs |

## Verification
The assertions check several rules on every clock cycle. A write strobe can only open when the gating strobes allow it. A byte can only be committed after a strobe of the minimum length. Programming can only start once the inactivity timer has reached its limit, and it holds until its counter ends. Neither the programmed page nor the last-byte register moves during programming. Every read in the busy phase carries the inverted bit 7, zeroed low bits and a flipped bit 6. Other properties can only be shown by the bench's scenarios: that the correct bytes land in the correct page, that rejected, off-page and mid-programming writes leave no trace in the array, and that the start delay and busy length come out right end to end.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eng_state_t;
endpackage

// File: rtl/eepw_strobe.sv
module eepw_strobe #(
  parameter int AW      = 10,
  parameter int MIN_LOW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          start_p,
  output logic          wr_active,
  output logic          commit,
  output logic [AW-1:0] c_addr,
  output logic [7:0]    c_data
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic          wr_now;
  logic [CW-1:0] low_cnt;
  logic [AW-1:0] addr_q;
  logic [7:0]    dat_q;

  assign wr_now = !cs_n && !we_n && oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_active <= 1'b0;
      start_p   <= 1'b0;
      commit    <= 1'b0;
      low_cnt   <= '0;
      addr_q    <= '0;
      dat_q     <= '0;
      c_addr    <= '0;
      c_data    <= '0;
    end else begin
      wr_active <= wr_now;
      start_p   <= wr_now && !wr_active;
      commit    <= 1'b0;
      if (wr_now && !wr_active) begin
        addr_q  <= addr;
        low_cnt <= CW'(1);
      end else if (wr_now && low_cnt != CW'(MIN_LOW)) begin
        low_cnt <= low_cnt + 1'b1;
      end
      if (wr_now) dat_q <= din;
      if (!wr_now && wr_active) begin
        commit <= (low_cnt >= CW'(MIN_LOW));
        c_addr <= addr_q;
        c_data <= dat_q;
      end
    end
  end

  // R1
  gate_open_chk: assert property (@(posedge clk) disable iff (rst)
    start_p |-> ($past(oe_n) && !$past(we_n) && !$past(cs_n)));

  // R3
  min_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    commit |-> ($past(low_cnt) >= CW'(MIN_LOW)));
endmodule

// File: rtl/eepw_pagebuf.sv
module eepw_pagebuf #(
  parameter int PAGE_BYTES = 256,
  parameter int OW         = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [OW-1:0] widx,
  input  logic [7:0]    wdata,
  input  logic          clr,
  input  logic [OW-1:0] ridx,
  output logic [7:0]    rdata,
  output logic          rvalid
);
  logic [7:0]            pmem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) pmem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      if (clr) vld[ridx] <= 1'b0;
      if (we)  vld[widx] <= 1'b1;
    end
  end

  assign rdata  = pmem[ridx];
  assign rvalid = vld[ridx];
endmodule

// File: rtl/eepw_ctrl.sv
module eepw_ctrl
  import eepw_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int PAGES      = 4,
  parameter int TIMEOUT    = 16,
  parameter int PROG_CYC   = 300,
  localparam int OW        = $clog2(PAGE_BYTES),
  localparam int AW        = $clog2(PAGE_BYTES * PAGES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_p,
  input  logic          wr_active,
  input  logic          commit,
  input  logic [AW-1:0] c_addr,
  input  logic [7:0]    c_data,
  output logic          busy,
  output logic          last_msb,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata
);
  localparam int PW       = AW - OW;
  localparam int PROG_LEN = (PROG_CYC > PAGE_BYTES) ? PROG_CYC : PAGE_BYTES;
  localparam int TW       = $clog2(TIMEOUT + 1);
  localparam int NW       = $clog2(PROG_LEN);

  eng_state_t    state;
  logic [PW-1:0] page;
  logic [TW-1:0] timer;
  logic [NW-1:0] cnt;
  logic [7:0]    last_data;
  logic          accept, copying, pb_valid;
  logic [OW-1:0] copy_idx;
  logic [7:0]    pb_data;

  assign accept   = commit && ((state == ST_IDLE) ||
                    (state == ST_LOAD && c_addr[AW-1:OW] == page));
  assign copying  = (state == ST_PROG) && ({1'b0, cnt} < (NW+1)'(PAGE_BYTES));
  assign copy_idx = cnt[OW-1:0];

  eepw_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .OW(OW)) u_pbuf (
    .clk(clk), .rst(rst), .we(accept), .widx(c_addr[OW-1:0]), .wdata(c_data),
    .clr(copying), .ridx(copy_idx), .rdata(pb_data), .rvalid(pb_valid)
  );

  assign mem_we    = copying && pb_valid;
  assign mem_waddr = {page, copy_idx};
  assign mem_wdata = pb_data;
  assign busy      = (state == ST_PROG);
  assign last_msb  = last_data[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      page      <= '0;
      timer     <= '0;
      cnt       <= '0;
      last_data <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_LOAD;
          page  <= c_addr[AW-1:OW];
          timer <= '0;
        end
        ST_LOAD: begin
          if (start_p || commit) timer <= '0;
          else if (timer != TW'(TIMEOUT)) timer <= timer + 1'b1;
          if (!wr_active && !start_p && !commit && timer == TW'(TIMEOUT)) begin
            state <= ST_PROG;
            cnt   <= '0;
          end
        end
        ST_PROG: begin
          if (cnt == NW'(PROG_LEN - 1)) state <= ST_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
      if (accept) last_data <= c_data;
    end
  end

  // R5
  window_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(state == ST_PROG) |-> ($past(timer) == TW'(TIMEOUT)));

  // R6
  prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG && cnt != NW'(PROG_LEN - 1)) |=> (state == ST_PROG));

  // R9
  busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROG) |=> ($stable(last_data) && $stable(page)));

  // R4
  off_page_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && commit && c_addr[AW-1:OW] != page) |=> $stable(last_data));
endmodule

// File: rtl/eeprom_page_engine.sv
module eeprom_page_engine #(
  parameter int PAGE_BYTES  = 256,
  parameter int PAGES       = 4,
  parameter int TIMEOUT_CYC = 16,
  parameter int PROG_CYC    = 300,
  parameter int MIN_LOW_CYC = 2,
  localparam int AW         = $clog2(PAGE_BYTES * PAGES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          busy
);
  localparam int DEPTH = PAGE_BYTES * PAGES;

  logic          start_p, wr_active, commit, last_msb, mem_we;
  logic [AW-1:0] c_addr, mem_waddr;
  logic [7:0]    c_data, mem_wdata;
  logic [7:0]    arr [DEPTH];
  logic          rd_now, rd_prev, tog, tog_n;

  eepw_strobe #(.AW(AW), .MIN_LOW(MIN_LOW_CYC)) u_strobe (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(wdata), .start_p(start_p), .wr_active(wr_active),
    .commit(commit), .c_addr(c_addr), .c_data(c_data)
  );

  eepw_ctrl #(.PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES), .TIMEOUT(TIMEOUT_CYC),
              .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .start_p(start_p), .wr_active(wr_active),
    .commit(commit), .c_addr(c_addr), .c_data(c_data), .busy(busy),
    .last_msb(last_msb), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (mem_we) arr[mem_waddr] <= mem_wdata;
  end

  assign rd_now = !cs_n && !oe_n;
  assign tog_n  = rd_prev ? tog : ~tog;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      rd_prev <= 1'b0;
      tog     <= 1'b0;
    end else begin
      rd_prev <= rd_now;
      if (rd_now) begin
        if (busy) begin
          rdata <= {~last_msb, tog_n, 6'd0};
          tog   <= tog_n;
        end else begin
          rdata <= arr[addr];
        end
      end else begin
        rdata <= '0;
      end
    end
  end

  // R7
  status_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_now && busy) |=> ((rdata[7] == ~$past(last_msb)) && (rdata[5:0] == 6'd0)));

  // R8
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_now && !rd_prev && busy) |=> (rdata[6] != $past(tog)));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_now |=> (rdata == 8'd0));
endmodule

// File: tb/eeprom_page_engine_test.sv
module eeprom_page_engine_test;
  localparam int PB = 256;
  localparam int NP = 4;
  localparam int TIMEOUT = 16;
  localparam int PROG_CYC = 300;
  localparam int MIN_LOW = 2;
  localparam int PROG_LEN = (PROG_CYC > PB) ? PROG_CYC : PB;

  logic clk = 1'b0;
  logic rst, cs_n, oe_n, we_n, busy;
  logic [9:0] addr;
  logic [7:0] wdata, rdata;

  int checks = 0;
  int fails = 0;
  int busy_cnt = 0;
  logic [7:0] model [PB*NP];
  logic [7:0] pend [PB];
  bit pendv [PB];
  logic [7:0] last_d;
  int last_a, cur_page;

  eeprom_page_engine #(.PAGE_BYTES(PB), .PAGES(NP), .TIMEOUT_CYC(TIMEOUT),
    .PROG_CYC(PROG_CYC), .MIN_LOW_CYC(MIN_LOW)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (busy) busy_cnt++;

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    report();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d, input int len);
    @(negedge clk);
    addr = a[9:0]; wdata = d[7:0]; cs_n = 1'b0; we_n = 1'b0;
    repeat (len) @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    addr = a[9:0]; cs_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    v = rdata;
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic accept_byte(input int a, input int d);
    pend[a % PB] = d[7:0];
    pendv[a % PB] = 1'b1;
    last_d = d[7:0];
    last_a = a;
    cur_page = a / PB;
  endtask

  task automatic finish_page();
    int n;
    logic [7:0] v;
    bit p6;
    busy_cnt = 0;
    n = 0;
    while (!busy && n < 100) begin @(negedge clk); n++; end
    chk(n >= TIMEOUT + 1 && n <= TIMEOUT + 4, "R5 programming start delay", n, TIMEOUT + 3);
    p6 = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (i == 3) wr(last_a, {~last_d[7], last_d[6:0]}, 2);
      rd(last_a, v);
      chk(v[7] == ~last_d[7] && v[5:0] == 6'd0,
          (i > 3) ? "R9 status after write during busy" : "R7 status byte",
          v, {~last_d[7], v[6], 6'd0});
      if (i > 0) chk(v[6] != p6, "R8 toggle bit", v[6], ~p6);
      p6 = v[6];
    end
    n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    idle(2);
    chk(busy_cnt == PROG_LEN, "R6 busy length", busy_cnt, PROG_LEN);
    for (int o = 0; o < PB; o++) begin
      if (pendv[o]) begin
        model[cur_page*PB + o] = pend[o];
        pendv[o] = 1'b0;
        rd(cur_page*PB + o, v);
        chk(v == model[cur_page*PB + o], "R10 programmed byte readback", v, model[cur_page*PB + o]);
      end
    end
  endtask

  initial begin
    logic [7:0] v;
    int a, b, d, first_a, other_a, n;
    rst = 1'b1; cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; wdata = '0;
    void'($urandom(32'd4711));
    for (int o = 0; o < PB; o++) pendv[o] = 1'b0;
    idle(3);
    chk(busy == 1'b0, "R11 busy in reset", busy, 0);
    rst = 1'b0;
    idle(1);
    chk(busy == 1'b0 && rdata == 8'd0, "R11 outputs after reset", {busy, rdata}, 0);

    // full pages, back-to-back bytes (R5 window kept open by steady strobes)
    for (int p = 0; p < NP; p++) begin
      for (int o = 0; o < PB; o++) begin
        d = $urandom & 8'hff;
        wr(p*PB + o, d, MIN_LOW);
        accept_byte(p*PB + o, d);
      end
      chk(busy == 1'b0, "R5 no programming while loading", busy, 0);
      finish_page();
    end
    idle(1);
    chk(rdata == 8'd0, "R10 rdata zero without read", rdata, 0);

    // R1: OE low blocks a write
    a = 1*PB + 17;
    @(negedge clk);
    addr = a[9:0]; wdata = ~model[a]; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    idle(3);
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    busy_cnt = 0;
    idle(TIMEOUT + 10);
    chk(busy_cnt == 0, "R1 OE low write no programming", busy_cnt, 0);
    rd(a, v);
    chk(v == model[a], "R1 OE low write array unchanged", v, model[a]);

    // R1: CE high blocks a write
    @(negedge clk);
    addr = a[9:0]; wdata = ~model[a]; we_n = 1'b0;
    idle(3);
    we_n = 1'b1;
    busy_cnt = 0;
    idle(TIMEOUT + 10);
    chk(busy_cnt == 0, "R1 CE high write no programming", busy_cnt, 0);
    rd(a, v);
    chk(v == model[a], "R1 CE high write array unchanged", v, model[a]);

    // R2: address from strobe start, data from strobe end
    a = 2*PB + 5; b = 2*PB + 9; d = {~model[a][7], model[a][6:0]} ^ 8'h3c;
    @(negedge clk);
    addr = a[9:0]; wdata = ~d[7:0]; cs_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    addr = b[9:0]; wdata = d[7:0];
    idle(2);
    cs_n = 1'b1; we_n = 1'b1;
    accept_byte(a, d);
    finish_page();
    rd(b, v);
    chk(v == model[b], "R2 later address not written", v, model[b]);
    rd(a, v);
    chk(v == d[7:0], "R2 data taken at strobe end", v, d);

    // random rounds with glitch and off-page writes
    for (int r = 0; r < 6; r++) begin
      cur_page = $urandom % NP;
      first_a = cur_page*PB + ($urandom % PB);
      d = $urandom & 8'hff;
      wr(first_a, d, MIN_LOW + ($urandom % 2));
      accept_byte(first_a, d);
      other_a = ((cur_page + 1) % NP)*PB + (first_a % PB);
      n = 3 + ($urandom % 8);
      for (int k = 1; k < n; k++) begin
        idle($urandom % 4);
        if (k == 2) begin
          wr(first_a, ~pend[first_a % PB], MIN_LOW - 1);
        end else if (k == 3) begin
          wr(other_a, ~model[other_a], MIN_LOW);
        end else begin
          a = cur_page*PB + ($urandom % PB);
          d = $urandom & 8'hff;
          wr(a, d, MIN_LOW + ($urandom % 2));
          accept_byte(a, d);
        end
        chk(busy == 1'b0, "R5 short gap keeps loading", busy, 0);
      end
      finish_page();
      rd(other_a, v);
      chk(v == model[other_a], "R4 off-page byte ignored", v, model[other_a]);
      rd(first_a, v);
      chk(v == model[first_a], "R3 short strobe ignored", v, model[first_a]);
    end

    report();
    $finish;
  end
endmodule